// File: doc/BRIEF.md
# EDO Hyper-Page Burst Controller

This block drives an EDO DRAM through a burst of column accesses that all fall in one row. It drops the row strobe once and then pulses the column strobe once per beat, each beat being either a read or an early write. The host gives a row, a start column and a beat count, and the columns then step up by one per beat, wrapping at the top of the column space. For writes the host presents one beat of data and lane enables at a time and advances when the block pulses a take strobe. For reads the block returns one word per beat with a one-cycle valid strobe, in column order.

All DRAM timing is counted in clock cycles through parameters: row-to-column delay, column strobe low and high widths (their sum is the page cycle), the row hold after the last column precharge, the row precharge, and a ceiling on how long the row strobe may stay low. Read data is sampled in the last cycle of each column-strobe-high slot, just before the next falling edge, which relies on the EDO output hold past the rising edge. When another beat would push the row-low time past the ceiling, the block closes the row, precharges, reopens the same row and carries on with the next column. The ceiling must be at least `T_RCD + CAS_LO + CAS_HI + RAS_TAIL` cycles.

Top module: `edo_page_burst`

## Requirements
- R1: During and after reset the row strobe, all column strobes and the write strobe are high (inactive), `busy`, `done`, `rd_valid`, `wr_take` and `ram_dq_oe` are low.
- R2: After `start` the row strobe falls with `row_in` on `ram_addr` and stays low for exactly `T_RCD` cycles before the first column strobe falls. Beat k presents column `col_in + k` (modulo 2^ADDR_W) on `ram_addr` while its column strobe is low.
- R3: Each beat keeps the column strobe low for exactly `CAS_LO` cycles. Between two beats in one row opening it stays high for exactly `CAS_HI` cycles.
- R4: In a read burst every lane of the column strobe falls together. The word on `ram_dq_in` in the last column-strobe-high cycle of each beat is returned on `rd_data` with a one-cycle `rd_valid` pulse, one pulse per beat, in column order.
- R5: In a write burst `ram_we_n` is low for the whole burst. Beat data sits on `ram_dq_out` and `ram_addr` from the column strobe falling edge until it rises. Lane b of `ram_cas_n` (data bits 8b+7..8b) falls only when bit b of `wr_be` is 1, so lanes with a 0 bit leave that byte unchanged. `wr_take` pulses once per beat in the cycle after that beat's data is taken.
- R6: After the last column strobe of a row opening rises, the row strobe stays low for `CAS_HI + RAS_TAIL` cycles and then stays high for `T_RP` cycles before any reopening. No column strobe is low while the row strobe is high.
- R7: The row strobe is never low for more than `RAS_MAX` cycles. A burst that would exceed this is split: the row is closed, precharged and reopened with the same row address, and the burst continues with the next column. With default timing and `RAS_MAX = 20`, each opening carries 5 beats.
- R8: `busy` is high from the cycle after `start` is accepted until the burst ends, and `done` pulses for one cycle with `busy` low when the final precharge completes.
- R9: `len_m1` holds the beat count minus one, so 0 gives a 1-beat burst and 255 gives a 256-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst (accepted when idle) |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| row_in | input | ADDR_W | Row address |
| col_in | input | ADDR_W | First column address |
| len_m1 | input | LEN_W | Beat count minus one |
| wr_data | input | DQ_W | Write data of the current beat |
| wr_be | input | DQ_W/8 | Lane enables of the current beat |
| wr_take | output | 1 | Current write beat consumed |
| rd_data | output | DQ_W | Returned read word |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | DQ_W/8 | Per-lane column strobes, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_addr | output | ADDR_W | Multiplexed row/column address |
| ram_dq_out | output | DQ_W | Data toward the DRAM |
| ram_dq_oe | output | 1 | Output enable for ram_dq_out |
| ram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The hardest case to reach is the row split: the ceiling must run out in the middle of a burst, with the precharge and reopening landing between two beats, while both the data order and the column sequence stay intact. The bench shrinks the ceiling to 20 cycles so that bursts of 6, 12 and 256 beats each cross several openings. A bench DRAM model latches addresses on strobe edges and changes its read data only after the next column strobe falls. A capture made at the wrong edge therefore returns the previous column's word. Every strobe run length is measured against its parameter.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_CLO,
    ST_CHI,
    ST_TAIL,
    ST_PRE
  } edo_st_e;
endpackage

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int RAS_MAX = 20000,
  parameter int NEED    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic fits
);
  localparam int CW = $clog2(RAS_MAX + 1) + 1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= '0;
    else if (ras_n) low_cnt <= '0;
    else            low_cnt <= low_cnt + CW'(1);
  end

  // one more beat plus its closing tail must still fit under the ceiling
  always_comb fits = (32'(low_cnt) + 32'd1 + 32'(NEED)) <= 32'(RAS_MAX);

  // R7
  ras_limit_chk: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (32'(low_cnt) < 32'(RAS_MAX)));
endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture #(
  parameter int DQ_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/edo_burst_seq.sv
module edo_burst_seq
  import edo_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DQ_W     = 32,
  parameter int LEN_W    = 8,
  parameter int T_RCD    = 2,
  parameter int CAS_LO   = 2,
  parameter int CAS_HI   = 1,
  parameter int RAS_TAIL = 3,
  parameter int T_RP     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] row_in,
  input  logic [ADDR_W-1:0] col_in,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic [DQ_W/8-1:0] wr_be,
  input  logic              fits,
  output logic              ras_n,
  output logic [DQ_W/8-1:0] cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              wr_take,
  output logic              cap_en,
  output logic              busy,
  output logic              done
);
  localparam int PH_W = $clog2(T_RCD + CAS_LO + CAS_HI + RAS_TAIL + T_RP + 1);
  localparam int LF_W = LEN_W + 1;

  edo_st_e           st;
  logic [PH_W-1:0]   ph;
  logic [LF_W-1:0]   left;
  logic [ADDR_W-1:0] col_r, row_r;
  logic              wmode, ph_end, launch;

  always_comb begin
    ph_end = (ph == '0);
    launch = ph_end && ((st == ST_RCD) || (st == ST_CHI && left != '0 && fits));
    cap_en = !wmode && (st == ST_CHI) && ph_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  ph <= '0;  left <= '0;  col_r <= '0;  row_r <= '0;
      wmode <= 1'b0;  ras_n <= 1'b1;  cas_n <= '1;  we_n <= 1'b1;
      addr <= '0;  dq_out <= '0;  dq_oe <= 1'b0;  wr_take <= 1'b0;
      busy <= 1'b0;  done <= 1'b0;
    end else begin
      wr_take <= 1'b0;
      done    <= 1'b0;
      if (launch) begin
        st    <= ST_CLO;
        ph    <= PH_W'(CAS_LO - 1);
        addr  <= col_r;
        col_r <= col_r + ADDR_W'(1);
        left  <= left - LF_W'(1);
        cas_n <= wmode ? ~wr_be : '0;
        if (wmode) begin
          dq_out  <= wr_data;
          dq_oe   <= 1'b1;
          wr_take <= 1'b1;
        end
      end else begin
        case (st)
          ST_IDLE: if (start) begin
            st    <= ST_RCD;
            ph    <= PH_W'(T_RCD - 1);
            row_r <= row_in;
            col_r <= col_in;
            left  <= {1'b0, len_m1} + LF_W'(1);
            wmode <= is_write;
            we_n  <= ~is_write;
            ras_n <= 1'b0;
            addr  <= row_in;
            busy  <= 1'b1;
          end
          ST_RCD: ph <= ph - PH_W'(1);
          ST_CLO: if (ph_end) begin
            cas_n <= '1;
            st    <= ST_CHI;
            ph    <= PH_W'(CAS_HI - 1);
          end else ph <= ph - PH_W'(1);
          ST_CHI: if (ph_end) begin
            st <= ST_TAIL;
            ph <= PH_W'(RAS_TAIL - 1);
          end else ph <= ph - PH_W'(1);
          ST_TAIL: if (ph_end) begin
            ras_n <= 1'b1;
            st    <= ST_PRE;
            ph    <= PH_W'(T_RP - 1);
          end else ph <= ph - PH_W'(1);
          ST_PRE: if (ph_end) begin
            if (left != '0) begin
              ras_n <= 1'b0;
              addr  <= row_r;
              st    <= ST_RCD;
              ph    <= PH_W'(T_RCD - 1);
            end else begin
              st    <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
              we_n  <= 1'b1;
              dq_oe <= 1'b0;
            end
          end else ph <= ph - PH_W'(1);
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R6
  cas_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ras_n |-> (&cas_n));

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLO && $past(st) == ST_CLO && !(&cas_n)) |-> ($stable(dq_out) && $stable(addr)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3
  cas_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHI) |-> (&cas_n && !ras_n));
endmodule

// File: rtl/edo_page_burst.sv
module edo_page_burst #(
  parameter int ADDR_W   = 10,
  parameter int DQ_W     = 32,
  parameter int LEN_W    = 8,
  parameter int T_RCD    = 2,
  parameter int CAS_LO   = 2,
  parameter int CAS_HI   = 1,
  parameter int RAS_TAIL = 3,
  parameter int T_RP     = 3,
  parameter int RAS_MAX  = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] row_in,
  input  logic [ADDR_W-1:0] col_in,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic [DQ_W/8-1:0] wr_be,
  output logic              wr_take,
  output logic [DQ_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              ram_ras_n,
  output logic [DQ_W/8-1:0] ram_cas_n,
  output logic              ram_we_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DQ_W-1:0]   ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DQ_W-1:0]   ram_dq_in
);
  localparam int NEED = CAS_LO + CAS_HI + RAS_TAIL;

  logic fits, cap_en;

  edo_ras_guard #(.RAS_MAX(RAS_MAX), .NEED(NEED)) u_guard (
    .clk(clk), .rst(rst), .ras_n(ram_ras_n), .fits(fits)
  );

  edo_burst_seq #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .LEN_W(LEN_W), .T_RCD(T_RCD),
    .CAS_LO(CAS_LO), .CAS_HI(CAS_HI), .RAS_TAIL(RAS_TAIL), .T_RP(T_RP)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .is_write(is_write),
    .row_in(row_in), .col_in(col_in), .len_m1(len_m1),
    .wr_data(wr_data), .wr_be(wr_be), .fits(fits),
    .ras_n(ram_ras_n), .cas_n(ram_cas_n), .we_n(ram_we_n), .addr(ram_addr),
    .dq_out(ram_dq_out), .dq_oe(ram_dq_oe), .wr_take(wr_take),
    .cap_en(cap_en), .busy(busy), .done(done)
  );

  edo_rd_capture #(.DQ_W(DQ_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .dq_in(ram_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/tb_edo_page_burst.sv
`timescale 1ns/1ps
module tb_edo_page_burst;
  localparam int ADDR_W = 10, DQ_W = 32, LEN_W = 8, BE_W = DQ_W/8;
  localparam int T_RCD = 2, CAS_LO = 2, CAS_HI = 1, RAS_TAIL = 3, T_RP = 3;
  localparam int RAS_MAX = 20;
  localparam int PER_OPEN = (RAS_MAX - T_RCD - RAS_TAIL) / (CAS_LO + CAS_HI);

  logic clk = 0, rst = 1, start = 0, is_write = 0;
  logic [ADDR_W-1:0] row_in = '0, col_in = '0;
  logic [LEN_W-1:0] len_m1 = '0;
  logic [DQ_W-1:0] wr_data, rd_data, ram_dq_out, ram_dq_in;
  logic [BE_W-1:0] wr_be, ram_cas_n;
  logic wr_take, rd_valid, busy, done, ram_ras_n, ram_we_n, ram_dq_oe;
  logic [ADDR_W-1:0] ram_addr;

  always #5 clk = ~clk;

  edo_page_burst #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .LEN_W(LEN_W), .T_RCD(T_RCD),
    .CAS_LO(CAS_LO), .CAS_HI(CAS_HI), .RAS_TAIL(RAS_TAIL), .T_RP(T_RP),
    .RAS_MAX(RAS_MAX)) dut (.*);

  int checks = 0, errors = 0;
  logic [DQ_W-1:0] mem [0:1023];
  logic [DQ_W-1:0] exp_mem [0:1023];
  logic [DQ_W-1:0] wbuf [0:255];
  logic [BE_W-1:0] bbuf [0:255];
  logic [DQ_W-1:0] rbuf [0:511];
  logic [ADDR_W-1:0] col_log [0:511];
  int widx, rcnt, takes, ras_falls, cas_falls, viol, viol_row;
  logic [ADDR_W-1:0] exp_row, row_l;

  assign wr_data = wbuf[widx[7:0]];
  assign wr_be   = bbuf[widx[7:0]];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (wr_take) begin widx++; takes++; end
  always @(posedge clk) if (!rst && rd_valid) begin rbuf[rcnt] = rd_data; rcnt++; end

  // DRAM model and strobe timing monitor
  logic p_ras, p_cas, cas_lo_s, first_b;
  int ras_run, cas_run, o_ras, o_cas;
  always @(posedge clk) begin
    if (rst) begin
      p_ras = 1; p_cas = 0; ras_run = 0; cas_run = 0; first_b = 0;
    end else begin
      o_ras = ras_run; o_cas = cas_run;
      cas_lo_s = ~&ram_cas_n;
      if (p_ras && !ram_ras_n) begin
        ras_falls++;
        if (ras_falls > 1 && o_ras != T_RP) viol++;
        if (ram_addr != exp_row) viol_row++;
        row_l = ram_addr; first_b = 1; ras_run = 1;
      end else if (!p_ras && ram_ras_n) begin
        if (o_ras > RAS_MAX) viol++;
        if (o_cas != CAS_HI + RAS_TAIL) viol++;
        ras_run = 1;
      end else ras_run++;
      if (cas_lo_s && !p_cas) begin
        if (first_b) begin
          if (o_ras != T_RCD) viol++;
          first_b = 0;
        end else if (o_cas != CAS_HI) viol++;
        if (ram_ras_n) viol++;
        col_log[cas_falls] = ram_addr;
        cas_falls++;
        if (!ram_we_n) begin
          for (int b = 0; b < BE_W; b++)
            if (!ram_cas_n[b]) mem[{row_l[4:0], ram_addr[4:0]}][8*b +: 8] = ram_dq_out[8*b +: 8];
        end else begin
          if (ram_cas_n != '0) viol++;
          ram_dq_in <= mem[{row_l[4:0], ram_addr[4:0]}];
        end
        cas_run = 1;
      end else if (!cas_lo_s && p_cas) begin
        if (o_cas != CAS_LO) viol++;
        cas_run = 1;
      end else cas_run++;
      p_ras = ram_ras_n; p_cas = cas_lo_s;
    end
  end

  task automatic run_burst(input bit wr, input logic [ADDR_W-1:0] r, input logic [ADDR_W-1:0] c, input int n);
    int guard = 0;
    widx = 0; takes = 0; rcnt = 0; ras_falls = 0; cas_falls = 0; viol = 0; viol_row = 0;
    exp_row = r;
    @(negedge clk);
    is_write = wr; row_in = r; col_in = c; len_m1 = LEN_W'(n - 1); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done && !busy, "R8 done with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R8 done single pulse", done, 0);
    chk(viol == 0, "R3 R6 strobe timing violations", viol, 0);
    chk(viol_row == 0, "R7 reopen uses same row", viol_row, 0);
    chk(ras_falls == (n + PER_OPEN - 1) / PER_OPEN, "R7 row openings", ras_falls, (n + PER_OPEN - 1) / PER_OPEN);
    chk(cas_falls == n, "R9 beat count", cas_falls, n);
    for (int k = 0; k < n; k++) begin
      logic [ADDR_W-1:0] ec;
      ec = c + ADDR_W'(k);
      if (col_log[k] != ec) begin
        chk(0, "R2 column sequence", col_log[k], ec);
        break;
      end
    end
    chk(1, "R2 column sequence", 0, 0);
  endtask

  task automatic t_write(input logic [ADDR_W-1:0] r, input logic [ADDR_W-1:0] c, input int n, input int seed, input bit masked);
    for (int k = 0; k < n; k++) begin
      wbuf[k] = 32'h1000_0001 * (k + 1) + 32'(seed);
      bbuf[k] = masked ? BE_W'(k % 15 + 1) : '1;
      for (int b = 0; b < BE_W; b++)
        if (bbuf[k][b]) exp_mem[{r[4:0], 5'(c + ADDR_W'(k))}][8*b +: 8] = wbuf[k][8*b +: 8];
    end
    run_burst(1, r, c, n);
    chk(takes == n, "R5 take pulses", takes, n);
    for (int k = 0; k < n; k++) begin
      logic [9:0] ix;
      ix = {r[4:0], 5'(c + ADDR_W'(k))};
      chk(mem[ix] == exp_mem[ix], "R5 written word with lane mask", mem[ix], exp_mem[ix]);
    end
  endtask

  task automatic t_read(input logic [ADDR_W-1:0] r, input logic [ADDR_W-1:0] c, input int n);
    int bad = 0;
    run_burst(0, r, c, n);
    chk(rcnt == n, "R4 valid pulse count", rcnt, n);
    chk(takes == 0, "R4 no take in read", takes, 0);
    for (int k = 0; k < n; k++) begin
      logic [9:0] ix;
      ix = {r[4:0], 5'(c + ADDR_W'(k))};
      if (rbuf[k] != exp_mem[ix] && bad == 0) begin
        chk(0, "R4 read data order", rbuf[k], exp_mem[ix]);
        bad = 1;
      end
    end
    if (bad == 0) chk(1, "R4 read data order", 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    for (int i = 0; i < 256; i++) begin wbuf[i] = '0; bbuf[i] = '0; end
    ram_dq_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ram_ras_n && (&ram_cas_n) && ram_we_n, "R1 strobes idle in reset", {ram_ras_n, ram_cas_n, ram_we_n}, 6'h3f);
    chk(!busy && !done && !rd_valid && !wr_take && !ram_dq_oe, "R1 status low in reset",
        {busy, done, rd_valid, wr_take, ram_dq_oe}, 0);
    rst = 0;
    @(negedge clk);
    chk(ram_ras_n && !busy, "R1 idle after reset", {ram_ras_n, busy}, 2'b10);
    t_write(10'd3, 10'd4, 12, 16'h55, 0);   // R7 split across three openings
    t_write(10'd3, 10'd6, 3, 16'h77, 1);    // R5 lane masks
    t_read(10'd3, 10'd4, 12);               // R4 readback incl. masked bytes
    t_read(10'd3, 10'd10, 1);               // R9 single beat
    t_write(10'd7, 10'd1022, 6, 16'h99, 0); // R2 column wrap, R7 split at 6
    t_read(10'd7, 10'd1022, 6);
    t_read(10'd3, 10'd0, 256);              // R9 longest burst
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule